// File: doc/BRIEF.md
# Confidence-Gated Last-Value Result Predictor

This block predicts the result of an instruction from the result that the same instruction produced last time. At fetch the pipeline presents an instruction address. One cycle later the block returns the stored 64-bit value and a flag that says whether the pipeline should use it. The flag comes from a second table of 2-bit saturating confidence counters. That table is indexed by the same address but can have a different depth from the value table.

When the instruction completes, the pipeline reports its address and the result it actually computed. The block compares that result with the stored value and moves the confidence counter up or down. It then decides whether to write the actual result into the value table. A counter at its highest state protects the stored value from a single wrong outcome. Every value entry carries a tag and a valid bit, so an instruction seen for the first time, or a different instruction that maps to the same entry, is treated as a miss. A miss never yields a usable prediction.

Top module: `result_predictor`

## Requirements
- R1: After reset every valid bit is clear and every counter is 0. No response is flagged (`predValid` low) until a lookup is made, and every lookup misses until an update installs an entry.
- R2: A lookup presented in one cycle produces `predValid`, `predValue` and `predUse` at the next clock edge. `predValid` is low in any cycle that follows a cycle with no lookup.
- R3: On a lookup miss (valid bit clear, or stored tag unequal to the address bits above the index), `predValue` is 0 and `predUse` is 0, whatever the counter holds.
- R4: An update that misses writes the actual result into the value entry, writes the new tag and sets the valid bit.
- R5: An update whose actual result equals the stored value of a hitting entry increments the counter, saturating at 3. Any other update, a miss included, decrements it, saturating at 0.
- R6: On a hit, `predUse` is 1 when the counter is 2 or 3 and 0 when it is 0 or 1.
- R7: A wrong update to a hitting entry whose counter was 3 keeps the stored value.
- R8: A wrong update to a hitting entry whose counter was 0, 1 or 2 replaces the stored value with the actual result.
- R9: When a lookup and an update address the same entries in the same cycle, the lookup response reflects the contents from before that update.
- R10: The value index is address bits [VAL_IDX_W+1:2] and the counter index is address bits [CONF_IDX_W+1:2]. Address bits [1:0] are ignored. The tag is the address bits above the value index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupPc | input | PC_W | Instruction address to predict |
| updValid | input | 1 | A completed instruction is reported this cycle |
| updPc | input | PC_W | Address of the completed instruction |
| updResult | input | DATA_W | Result the instruction actually produced |
| predValid | output | 1 | Registered response to last cycle's lookup |
| predValue | output | DATA_W | Stored value on a hit, 0 on a miss |
| predUse | output | 1 | Hit and counter at 2 or higher |

## Verification
The bench targets the counter edges. It drives a counter into 3 and then gives two wrong outcomes. A design that ignored the top-state protection would replace the value on the first wrong outcome, not the second. A design that failed to saturate would wrap around to 0 or to 3. It also looks up an address that shares both indices with a trained entry but has a different tag. A predictor that skipped the tag check would return a confident prediction of the wrong instruction's value. Same-cycle lookups and updates to one entry catch a design that forwards the new contents. Addresses with nonzero low bits catch a design that indexes from bit 0.

// File: rtl/rp_pkg.sv
package rp_pkg;
  // Confidence counter width is fixed by the four-state scheme.
  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  // Strobes passed from control to datapath for one update.
  typedef struct packed {
    logic              valWr;
    logic              confWr;
    logic [CONF_W-1:0] confNext;
  } rpStrobe_t;
endpackage

// File: rtl/rp_control.sv
module rp_control
  import rp_pkg::*;
(
  input  logic              updValid,
  input  logic              updHit,
  input  logic              updMatch,
  input  logic [CONF_W-1:0] updConf,
  output rpStrobe_t         strobe
);
  logic confTop;
  logic confZero;

  assign confTop  = (updConf == CONF_MAX);
  assign confZero = (updConf == '0);

  always_comb begin
    strobe = '0;
    if (updValid) begin
      strobe.confWr = 1'b1;
      if (updMatch) begin
        strobe.confNext = confTop ? updConf : updConf + 1'b1;
      end else begin
        strobe.confNext = confZero ? updConf : updConf - 1'b1;
      end
      // A miss always installs. A wrong hit replaces unless the counter is at the top.
      strobe.valWr = !updHit || (!updMatch && !confTop);
    end
  end
endmodule

// File: rtl/rp_datapath.sv
module rp_datapath
  import rp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int DATA_W     = 64,
  parameter int VAL_DEPTH  = 4096,
  parameter int CONF_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic [DATA_W-1:0] updResult,
  input  rpStrobe_t         strobe,
  output logic              updHit,
  output logic              updMatch,
  output logic [CONF_W-1:0] updConf,
  output logic              predValid,
  output logic [DATA_W-1:0] predValue,
  output logic              predUse
);
  localparam int VAL_IDX_W  = $clog2(VAL_DEPTH);
  localparam int CONF_IDX_W = $clog2(CONF_DEPTH);
  localparam int ALIGN_W    = 2;
  localparam int TAG_LSB    = ALIGN_W + VAL_IDX_W;
  localparam int TAG_W      = PC_W - TAG_LSB;

  logic [DATA_W-1:0] valMem  [VAL_DEPTH];
  logic [TAG_W-1:0]  tagMem  [VAL_DEPTH];
  logic [VAL_DEPTH-1:0] validBits;
  logic [CONF_W-1:0] confMem [CONF_DEPTH];

  // Update side address split.
  logic [VAL_IDX_W-1:0]  updValIdx;
  logic [CONF_IDX_W-1:0] updConfIdx;
  logic [TAG_W-1:0]      updTag;
  assign updValIdx  = updPc[ALIGN_W +: VAL_IDX_W];
  assign updConfIdx = updPc[ALIGN_W +: CONF_IDX_W];
  assign updTag     = updPc[TAG_LSB +: TAG_W];

  assign updHit   = validBits[updValIdx] && (tagMem[updValIdx] == updTag);
  assign updMatch = updHit && (valMem[updValIdx] == updResult);
  assign updConf  = confMem[updConfIdx];

  // Lookup side address split.
  logic [VAL_IDX_W-1:0]  lkValIdx;
  logic [CONF_IDX_W-1:0] lkConfIdx;
  logic [TAG_W-1:0]      lkTag;
  logic                  lkHit;
  assign lkValIdx  = lookupPc[ALIGN_W +: VAL_IDX_W];
  assign lkConfIdx = lookupPc[ALIGN_W +: CONF_IDX_W];
  assign lkTag     = lookupPc[TAG_LSB +: TAG_W];
  assign lkHit     = validBits[lkValIdx] && (tagMem[lkValIdx] == lkTag);

  // Registered response: reads old array contents at the same edge as writes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid <= 1'b0;
      predValue <= '0;
      predUse   <= 1'b0;
    end else begin
      predValid <= lookupValid;
      predValue <= (lookupValid && lkHit) ? valMem[lkValIdx] : '0;
      predUse   <= lookupValid && lkHit && confMem[lkConfIdx][CONF_W-1];
    end
  end

  // Value and tag storage: no reset, qualified by the valid bits.
  always_ff @(posedge clk) begin
    if (strobe.valWr) begin
      valMem[updValIdx] <= updResult;
      tagMem[updValIdx] <= updTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strobe.valWr) begin
      validBits[updValIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CONF_DEPTH; i++) confMem[i] <= '0;
    end else if (strobe.confWr) begin
      confMem[updConfIdx] <= strobe.confNext;
    end
  end
endmodule

// File: rtl/result_predictor.sv
module result_predictor
  import rp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int DATA_W     = 64,
  parameter int VAL_DEPTH  = 4096,
  parameter int CONF_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [DATA_W-1:0] updResult,
  output logic              predValid,
  output logic [DATA_W-1:0] predValue,
  output logic              predUse
);
  logic              updHit;
  logic              updMatch;
  logic [CONF_W-1:0] updConf;
  rpStrobe_t         strobe;

  rp_control u_ctrl (
    .updValid (updValid),
    .updHit   (updHit),
    .updMatch (updMatch),
    .updConf  (updConf),
    .strobe   (strobe)
  );

  rp_datapath #(
    .PC_W       (PC_W),
    .DATA_W     (DATA_W),
    .VAL_DEPTH  (VAL_DEPTH),
    .CONF_DEPTH (CONF_DEPTH)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .lookupPc    (lookupPc),
    .updPc       (updPc),
    .updResult   (updResult),
    .strobe      (strobe),
    .updHit      (updHit),
    .updMatch    (updMatch),
    .updConf     (updConf),
    .predValid   (predValid),
    .predValue   (predValue),
    .predUse     (predUse)
  );
endmodule

// File: rtl/rp_checker.sv
module rp_checker
  import rp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic              updValid,
  input logic              predValid,
  input logic              predUse,
  input logic              updHit,
  input logic              updMatch,
  input logic [CONF_W-1:0] updConf,
  input rpStrobe_t         strobe
);
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> predValid);

  assert_no_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid);

  assert_use_needs_resp_R6: assert property (@(posedge clk) disable iff (!rstN)
    predUse |-> predValid);

  assert_miss_installs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updHit) |-> strobe.valWr);

  assert_top_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updHit && !updMatch && updConf == CONF_MAX) |-> !strobe.valWr);

  assert_correct_counts_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updMatch && updConf != CONF_MAX) |-> (strobe.confNext == updConf + 1'b1));
endmodule

bind result_predictor rp_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .lookupValid (lookupValid),
  .updValid    (updValid),
  .predValid   (predValid),
  .predUse     (predUse),
  .updHit      (updHit),
  .updMatch    (updMatch),
  .updConf     (updConf),
  .strobe      (strobe)
);

// File: tb/result_predictor_bench.sv
`timescale 1ns/1ps
module result_predictor_bench;
  localparam int PC_W = 32;
  localparam int DATA_W = 64;
  localparam int VD = 64;
  localparam int CD = 16;
  localparam int VIW = 6;
  localparam int CIW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic [DATA_W-1:0] updResult = '0;
  logic predValid;
  logic [DATA_W-1:0] predValue;
  logic predUse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  result_predictor #(.PC_W(PC_W), .DATA_W(DATA_W), .VAL_DEPTH(VD), .CONF_DEPTH(CD)) u_result_predictor (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .updValid(updValid), .updPc(updPc), .updResult(updResult),
    .predValid(predValid), .predValue(predValue), .predUse(predUse));

  // Reference model state, built from the requirements.
  bit              mValid [VD];
  logic [PC_W-1:0] mTag   [VD];
  logic [DATA_W-1:0] mVal [VD];
  int              mConf  [CD];

  function automatic int vIdx(logic [PC_W-1:0] pc); return int'(pc[2 +: VIW]); endfunction
  function automatic int cIdx(logic [PC_W-1:0] pc); return int'(pc[2 +: CIW]); endfunction
  function automatic logic [PC_W-1:0] tagOf(logic [PC_W-1:0] pc); return pc >> (2 + VIW); endfunction
  function automatic bit hitOf(logic [PC_W-1:0] pc);
    return mValid[vIdx(pc)] && (mTag[vIdx(pc)] == tagOf(pc));
  endfunction

  function automatic void modelUpdate(logic [PC_W-1:0] pc, logic [DATA_W-1:0] res);
    int vi = vIdx(pc);
    int ci = cIdx(pc);
    bit hit = hitOf(pc);
    bit ok = hit && (mVal[vi] == res);
    int old = mConf[ci];
    if (ok) mConf[ci] = (old == 3) ? 3 : old + 1;
    else    mConf[ci] = (old == 0) ? 0 : old - 1;
    if (!hit || (!ok && old != 3)) begin
      mVal[vi] = res; mTag[vi] = tagOf(pc); mValid[vi] = 1'b1;
    end
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: inputs driven at the falling edge, response sampled one falling edge later.
  task automatic cycle(bit lv, logic [PC_W-1:0] lpc, bit uv, logic [PC_W-1:0] upc,
                       logic [DATA_W-1:0] ures, string tag);
    bit eHit;
    logic [DATA_W-1:0] eVal;
    bit eUse;
    lookupValid = lv; lookupPc = lpc; updValid = uv; updPc = upc; updResult = ures;
    eHit = hitOf(lpc);
    eVal = eHit ? mVal[vIdx(lpc)] : '0;
    eUse = eHit && (mConf[cIdx(lpc)] >= 2);
    if (uv) modelUpdate(upc, ures);
    @(negedge clk);
    check({tag, " R2 valid"}, 64'(predValid), 64'(lv));
    if (lv) begin
      check({tag, " value"}, predValue, eVal);
      check({tag, " use"}, 64'(predUse), 64'(eUse));
    end
  endtask

  task automatic upd(logic [PC_W-1:0] pc, logic [DATA_W-1:0] r, string tag);
    cycle(1'b0, '0, 1'b1, pc, r, tag);
  endtask
  task automatic look(logic [PC_W-1:0] pc, string tag);
    cycle(1'b1, pc, 1'b0, '0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pcA;
    logic [PC_W-1:0] pcB;
    logic [DATA_W-1:0] valX;
    logic [DATA_W-1:0] valY;
    logic [DATA_W-1:0] pool [8];
    void'($urandom(32'd7321));
    for (int i = 0; i < VD; i++) begin mValid[i] = 1'b0; mTag[i] = '0; mVal[i] = '0; end
    for (int i = 0; i < CD; i++) mConf[i] = 0;

    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(predValid), 64'd0);
    check("R1 reset use", 64'(predUse), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 64'(predValid), 64'd0);
    look(32'h0000_0010, "R1 empty lookup");
    look(32'h0000_1234, "R1 empty lookup");

    pcA  = 32'h0000_0010;
    pcB  = pcA + 32'h100;          // same value and counter index, different tag
    valX = 64'hDEAD_BEEF_0123_4567;
    valY = 64'h0BAD_F00D_89AB_CDEF;
    upd(pcA, valX, "R4 install");
    look(pcA, "R4 installed");
    upd(pcA, valX, "R5 up");
    look(pcA, "R6 conf1");
    upd(pcA, valX, "R5 up");
    look(pcA, "R6 conf2");
    upd(pcA, valX, "R5 up");
    upd(pcA, valX, "R5 saturate");
    look(pcA, "R5 conf3");
    look(pcB, "R3 alias miss");
    upd(pcA, valY, "R7 wrong at top");
    look(pcA, "R7 kept");
    upd(pcA, valY, "R8 wrong below top");
    look(pcA, "R8 replaced");
    look(pcA | 32'h3, "R10 low bits ignored");
    upd(pcA, 64'h1, "R5 down");
    upd(pcA, 64'h2, "R5 down");
    upd(pcA, 64'h3, "R5 floor");
    look(pcA, "R5 conf0");
    cycle(1'b1, pcA, 1'b1, pcA, 64'h3, "R9 same cycle");
    look(pcA, "R9 after update");
    upd(pcB, valX, "R4 alias install");
    look(pcA, "R3 evicted");
    look(pcB, "R4 alias hit");

    for (int i = 0; i < 8; i++) pool[i] = {$urandom, $urandom};
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] lp;
      logic [PC_W-1:0] up;
      logic [DATA_W-1:0] r;
      int s;
      lp = {22'($urandom_range(0, 1)), 6'($urandom_range(0, 7)), 2'($urandom)} ;
      up = {22'($urandom_range(0, 1)), 6'($urandom_range(0, 7)), 2'($urandom)} ;
      s = int'(up[4:2]);
      r = ($urandom_range(0, 3) != 0) ? pool[s] : {$urandom, $urandom};
      cycle(1'($urandom), lp, 1'($urandom), up, r, "R5 R6 R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule